// File: doc/BRIEF.md
# Register Integrity Monitor

This block sits next to a host-accessible register file. Whenever the host completes a transaction without error, the block keeps a copy of it: whether it was a read or a write, the address, and the data. The host can read that copy back to confirm that the transaction it meant to send is the one that arrived.

The block also checks the register contents in the background. It walks through a fixed set of covered words, one per clock, using a read port into the register file. The set is a group of configuration words plus a contiguous RAM window. As it walks, it folds each word into a rotate-and-XOR checksum. When a sweep finishes, it compares the result with the checksum from the previous sweep.

A sticky flag is raised in two cases: a successful host write, or a change in the checksum that means a covered word moved without being written. An active-low interrupt follows the flag whenever the matching mask bit is set.

Top module: `reg_integrity_mon`

## Requirements
- R1: After a transaction that completes without error (`txn_done`=1, `txn_err`=0), the record outputs show it on the next cycle. `last_kind` is 2'b01 for a read and 2'b10 for a write, and is 2'b00 after reset. `last_addr` and `last_data` hold the address and data of that transaction.
- R2: A transaction with `txn_err`=1 leaves all three record outputs unchanged and does not set the flag.
- R3: A successful write sets status bit 25 (`status_q[25]`) on the next cycle. A successful read does not set it. All other bits of `status_q` read 0.
- R4: The scan port presents one covered address per cycle. The order is the 13 configuration words 0x0100..0x010C, then the window 0x4380..0x43BE, then it wraps to 0x0100. It starts at 0x0100 on the first cycle after reset. Data returned on `scan_data` is expected one cycle after its address.
- R5: When a covered word changes without a host write, the flag is set within two full sweeps of the change.
- R6: Words outside the covered set (for example 0x00FF and 0x43BF) have no effect on the flag. In addition, a register file that stays unchanged never sets the flag, including during the first sweep after reset, which has no previous checksum to compare against.
- R7: The flag is sticky. It clears only on a cycle where `status_wr`=1 and `status_wbit`=1 (write-one-to-clear on bit 25). `status_wr` with `status_wbit`=0 leaves it set. If a set event and a clear arrive in the same cycle, the set wins.
- R8: `mask_wr` loads `mask_wbit` into `mask_q[25]`. `irq_n` is 0 exactly while both status bit 25 and mask bit 25 are 1. It returns to 1 in the same cycle in which either bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_done | input | 1 | Host transaction finished this cycle |
| txn_err | input | 1 | The finishing transaction had an error |
| txn_write | input | 1 | The finishing transaction is a write (0 = read) |
| txn_addr | input | 16 | Address of the finishing transaction |
| txn_data | input | 32 | Write data or returned read data |
| last_kind | output | 2 | Recorded kind: 01 read, 10 write, 00 none |
| last_addr | output | 16 | Recorded address |
| last_data | output | 32 | Recorded data |
| scan_addr | output | 16 | Address of the covered word being fetched |
| scan_data | input | 32 | Register file contents for the previous cycle's `scan_addr` |
| status_wr | input | 1 | Host write strobe for the status register |
| status_wbit | input | 1 | Bit 25 of the status write data (1 clears the flag) |
| mask_wr | input | 1 | Host write strobe for the mask register |
| mask_wbit | input | 1 | Bit 25 of the mask write data |
| status_q | output | 32 | Status register; only bit 25 is used |
| mask_q | output | 32 | Mask register; only bit 25 is used |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a covered word changing with no host write at all. The flag should then come only from the checksum comparison, and it must come at the extreme edges of the covered set. The bench owns the register file model behind the scan port. It flips words directly at the first and last configuration addresses and at 0x4380 and 0x43BE, with no host transaction. It then waits three sweeps, checks the flag, and clears it. Flipping words just outside the set, and a set event arriving together with a clear, cover the cases where the flag must stay as it was.

// File: rtl/integ_pkg.sv
package integ_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } op_kind_e;

  // one step of the running checksum: rotate left by one, fold in the word
  function automatic logic [31:0] chk_step(input logic [31:0] acc, input logic [31:0] word);
    return {acc[30:0], acc[31]} ^ word;
  endfunction
endpackage

// File: rtl/integ_record.sv
module integ_record #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          txn_done,
  input  logic          txn_err,
  input  logic          txn_write,
  input  logic [AW-1:0] txn_addr,
  input  logic [DW-1:0] txn_data,
  output logic [1:0]    last_kind,
  output logic [AW-1:0] last_addr,
  output logic [DW-1:0] last_data
);
  import integ_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_kind <= OP_NONE;
      last_addr <= '0;
      last_data <= '0;
    end else if (txn_done && !txn_err) begin
      last_kind <= txn_write ? OP_WRITE : OP_READ;
      last_addr <= txn_addr;
      last_data <= txn_data;
    end
  end
endmodule

// File: rtl/integ_sweep.sv
module integ_sweep #(
  parameter int            AW       = 16,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] CFG_BASE = 16'h0100,
  parameter int            NUM_CFG  = 13,
  parameter logic [AW-1:0] WIN_LO   = 16'h4380,
  parameter logic [AW-1:0] WIN_HI   = 16'h43BE
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] scan_addr,
  input  logic [DW-1:0] scan_data,
  output logic          mismatch
);
  import integ_pkg::*;

  localparam int WIN_WORDS = int'(WIN_HI) - int'(WIN_LO) + 1;
  localparam int TOTAL     = NUM_CFG + WIN_WORDS;
  localparam int IW        = $clog2(TOTAL);

  logic [IW-1:0] scan_idx;
  logic          d_vld, d_first, d_last;
  logic [DW-1:0] acc, acc_nxt, ref_q;
  logic          ref_vld;

  // index -> covered address: configuration group first, then the window
  always_comb begin
    if (scan_idx < IW'(NUM_CFG))
      scan_addr = CFG_BASE + AW'(scan_idx);
    else
      scan_addr = WIN_LO + (AW'(scan_idx) - AW'(NUM_CFG));
  end

  always_comb acc_nxt = chk_step(d_first ? '0 : acc, scan_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_idx <= '0;
      d_vld    <= 1'b0;
      d_first  <= 1'b0;
      d_last   <= 1'b0;
      acc      <= '0;
      ref_q    <= '0;
      ref_vld  <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      scan_idx <= (scan_idx == IW'(TOTAL - 1)) ? '0 : scan_idx + 1'b1;
      d_vld    <= 1'b1;
      d_first  <= (scan_idx == '0);
      d_last   <= (scan_idx == IW'(TOTAL - 1));
      mismatch <= 1'b0;
      if (d_vld) begin
        acc <= acc_nxt;
        if (d_last) begin
          ref_q    <= acc_nxt;
          ref_vld  <= 1'b1;
          mismatch <= ref_vld && (acc_nxt != ref_q);
        end
      end
    end
  end
endmodule

// File: rtl/integ_flag.sv
module integ_flag #(
  parameter int DW       = 32,
  parameter int FLAG_BIT = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_evt,
  input  logic          status_wr,
  input  logic          status_wbit,
  input  logic          mask_wr,
  input  logic          mask_wbit,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] mask_q,
  output logic          irq_n
);
  logic flag, mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      mask <= 1'b0;
    end else begin
      if (set_evt)
        flag <= 1'b1;
      else if (status_wr && status_wbit)
        flag <= 1'b0;
      if (mask_wr)
        mask <= mask_wbit;
    end
  end

  always_comb begin
    status_q           = '0;
    status_q[FLAG_BIT] = flag;
    mask_q             = '0;
    mask_q[FLAG_BIT]   = mask;
    irq_n              = ~(flag & mask);
  end
endmodule

// File: rtl/reg_integrity_mon.sv
module reg_integrity_mon #(
  parameter int            AW       = 16,
  parameter int            DW       = 32,
  parameter int            FLAG_BIT = 25,
  parameter logic [AW-1:0] CFG_BASE = 16'h0100,
  parameter int            NUM_CFG  = 13,
  parameter logic [AW-1:0] WIN_LO   = 16'h4380,
  parameter logic [AW-1:0] WIN_HI   = 16'h43BE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          txn_done,
  input  logic          txn_err,
  input  logic          txn_write,
  input  logic [AW-1:0] txn_addr,
  input  logic [DW-1:0] txn_data,
  output logic [1:0]    last_kind,
  output logic [AW-1:0] last_addr,
  output logic [DW-1:0] last_data,
  output logic [AW-1:0] scan_addr,
  input  logic [DW-1:0] scan_data,
  input  logic          status_wr,
  input  logic          status_wbit,
  input  logic          mask_wr,
  input  logic          mask_wbit,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] mask_q,
  output logic          irq_n
);
  logic mismatch;
  logic set_evt;

  assign set_evt = (txn_done && !txn_err && txn_write) || mismatch;

  integ_record #(.AW(AW), .DW(DW)) u_record (
    .clk(clk), .rst(rst),
    .txn_done(txn_done), .txn_err(txn_err), .txn_write(txn_write),
    .txn_addr(txn_addr), .txn_data(txn_data),
    .last_kind(last_kind), .last_addr(last_addr), .last_data(last_data)
  );

  integ_sweep #(
    .AW(AW), .DW(DW), .CFG_BASE(CFG_BASE), .NUM_CFG(NUM_CFG),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_sweep (
    .clk(clk), .rst(rst),
    .scan_addr(scan_addr), .scan_data(scan_data), .mismatch(mismatch)
  );

  integ_flag #(.DW(DW), .FLAG_BIT(FLAG_BIT)) u_flag (
    .clk(clk), .rst(rst), .set_evt(set_evt),
    .status_wr(status_wr), .status_wbit(status_wbit),
    .mask_wr(mask_wr), .mask_wbit(mask_wbit),
    .status_q(status_q), .mask_q(mask_q), .irq_n(irq_n)
  );
endmodule

// File: rtl/reg_integrity_mon_chk.sv
module reg_integrity_mon_chk #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int FLAG_BIT = 25
) (
  input logic          clk,
  input logic          rst,
  input logic          txn_done,
  input logic          txn_err,
  input logic          txn_write,
  input logic [AW-1:0] txn_addr,
  input logic [DW-1:0] txn_data,
  input logic [1:0]    last_kind,
  input logic [AW-1:0] last_addr,
  input logic [DW-1:0] last_data,
  input logic          status_wr,
  input logic          status_wbit,
  input logic          mask_wr,
  input logic          mask_wbit,
  input logic [DW-1:0] status_q,
  input logic [DW-1:0] mask_q,
  input logic          irq_n
);
  assert_record_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (txn_done && !txn_err) |=> (last_addr == $past(txn_addr) && last_data == $past(txn_data)));

  assert_record_kind_R1: assert property (@(posedge clk) disable iff (rst)
    (txn_done && !txn_err) |=> (last_kind == ($past(txn_write) ? 2'b10 : 2'b01)));

  assert_err_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (txn_done && txn_err) |=> ($stable(last_addr) && $stable(last_data) && $stable(last_kind)));

  assert_write_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (txn_done && !txn_err && txn_write) |=> status_q[FLAG_BIT]);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (status_q[FLAG_BIT] && !(status_wr && status_wbit)) |=> status_q[FLAG_BIT]);

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask_q[FLAG_BIT] == $past(mask_wbit)));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!status_q[FLAG_BIT] || !mask_q[FLAG_BIT]) |-> irq_n);
endmodule

bind reg_integrity_mon reg_integrity_mon_chk #(.AW(AW), .DW(DW), .FLAG_BIT(FLAG_BIT)) u_chk (.*);

// File: tb/reg_integrity_mon_bench.sv
module reg_integrity_mon_bench;
  localparam int NCFG  = 13;
  localparam int NWIN  = 63;
  localparam int TOTAL = NCFG + NWIN;
  localparam int B     = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txn_done = 0, txn_err = 0, txn_write = 0;
  logic [15:0] txn_addr = '0;
  logic [31:0] txn_data = '0;
  logic [1:0]  last_kind;
  logic [15:0] last_addr;
  logic [31:0] last_data;
  logic [15:0] scan_addr;
  logic [31:0] scan_data;
  logic        status_wr = 0, status_wbit = 0, mask_wr = 0, mask_wbit = 0;
  logic [31:0] status_q, mask_q;
  logic        irq_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // register file model behind the scan port
  logic [31:0] cfg_m [NCFG];
  logic [31:0] win_m [NWIN];
  logic [31:0] below_m, above_m;

  always #2 clk = ~clk;

  function automatic logic [31:0] rd(input logic [15:0] a);
    if (a >= 16'h0100 && a < 16'h0100 + NCFG) return cfg_m[a - 16'h0100];
    if (a >= 16'h4380 && a <= 16'h43BE)       return win_m[a - 16'h4380];
    if (a == 16'h00FF)                        return below_m;
    if (a == 16'h43BF)                        return above_m;
    return 32'hDEAD_0000 | 32'(a);
  endfunction

  always_ff @(posedge clk) scan_data <= rd(scan_addr);

  reg_integrity_mon u_reg_integrity_mon (
    .clk(clk), .rst(rst),
    .txn_done(txn_done), .txn_err(txn_err), .txn_write(txn_write),
    .txn_addr(txn_addr), .txn_data(txn_data),
    .last_kind(last_kind), .last_addr(last_addr), .last_data(last_data),
    .scan_addr(scan_addr), .scan_data(scan_data),
    .status_wr(status_wr), .status_wbit(status_wbit),
    .mask_wr(mask_wr), .mask_wbit(mask_wbit),
    .status_q(status_q), .mask_q(mask_q), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_txn(input logic wr, input logic err, input logic [15:0] a, input logic [31:0] d);
    txn_done = 1; txn_err = err; txn_write = wr; txn_addr = a; txn_data = d;
    @(negedge clk);
    txn_done = 0; txn_err = 0; txn_write = 0;
  endtask

  task automatic clear_flag();
    status_wr = 1; status_wbit = 1;
    @(negedge clk);
    status_wr = 0; status_wbit = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCFG; i++) cfg_m[i] = 32'h1000_0000 + 32'(i * 7);
    for (int i = 0; i < NWIN; i++) win_m[i] = 32'hA5A5_0000 ^ 32'(i * 32'h0101);
    below_m = 32'h1111_1111;
    above_m = 32'h2222_2222;

    idle(5);
    chk("R1 reset kind", 32'(last_kind), 32'h0);
    chk("R1 reset addr", 32'(last_addr), 32'h0);
    chk("R3 reset status", status_q, 32'h0);
    chk("R8 reset irq_n", 32'(irq_n), 32'h1);
    rst = 0;

    // R4: scan order over one full sweep and the wrap
    for (int k = 0; k <= TOTAL; k++) begin
      logic [15:0] e;
      if (k == TOTAL)     e = 16'h0100;
      else if (k < NCFG)  e = 16'h0100 + 16'(k);
      else                e = 16'h4380 + 16'(k - NCFG);
      chk("R4 scan_addr", 32'(scan_addr), 32'(e));
      @(negedge clk);
    end

    // R6: quiet register file never flags
    idle(3 * TOTAL);
    chk("R6 quiet no flag", status_q, 32'h0);

    // R1/R3: successful read recorded, no flag
    host_txn(1'b0, 1'b0, 16'h4390, 32'hCAFE_0001);
    chk("R1 read kind", 32'(last_kind), 32'h1);
    chk("R1 read addr", 32'(last_addr), 32'h4390);
    chk("R1 read data", last_data, 32'hCAFE_0001);
    chk("R3 read sets nothing", status_q, 32'h0);

    // R2: errored write ignored
    host_txn(1'b1, 1'b1, 16'h0105, 32'hBAD0_BAD0);
    chk("R2 err kind", 32'(last_kind), 32'h1);
    chk("R2 err addr", 32'(last_addr), 32'h4390);
    chk("R2 err data", last_data, 32'hCAFE_0001);
    chk("R2 err no flag", status_q, 32'h0);

    // R1/R3/R8: good write, mask off
    cfg_m[5] = 32'h5555_AAAA;
    host_txn(1'b1, 1'b0, 16'h0105, 32'h5555_AAAA);
    chk("R1 write kind", 32'(last_kind), 32'h2);
    chk("R1 write addr", 32'(last_addr), 32'h0105);
    chk("R1 write data", last_data, 32'h5555_AAAA);
    chk("R3 write sets bit 25", status_q, 32'h1 << B);
    chk("R8 masked irq_n high", 32'(irq_n), 32'h1);

    // R8: enable mask
    mask_wr = 1; mask_wbit = 1; @(negedge clk); mask_wr = 0; mask_wbit = 0;
    chk("R8 mask bit", mask_q, 32'h1 << B);
    chk("R8 irq_n low", 32'(irq_n), 32'h0);

    // R7: write of 0 does not clear
    status_wr = 1; status_wbit = 0; @(negedge clk); status_wr = 0;
    chk("R7 zero write keeps flag", status_q, 32'h1 << B);

    // let the checksum settle on the new contents, then clear
    idle(3 * TOTAL);
    clear_flag();
    chk("R7 cleared", status_q, 32'h0);
    chk("R8 irq_n high on clear", 32'(irq_n), 32'h1);
    idle(3 * TOTAL);
    chk("R6 settled no flag", status_q, 32'h0);

    // R5: spontaneous changes at the edges of the covered set
    for (int t = 0; t < 4; t++) begin
      case (t)
        0: win_m[0]        = win_m[0] ^ 32'h0000_0100;
        1: win_m[NWIN-1]   = win_m[NWIN-1] ^ 32'h8000_0000;
        2: cfg_m[0]        = cfg_m[0] ^ 32'h0000_0001;
        default: cfg_m[NCFG-1] = cfg_m[NCFG-1] ^ 32'h0F00_0000;
      endcase
      idle(3 * TOTAL);
      chk($sformatf("R5 spontaneous change %0d flagged", t), status_q, 32'h1 << B);
      chk($sformatf("R5 irq_n low %0d", t), 32'(irq_n), 32'h0);
      clear_flag();
      idle(2 * TOTAL);
      chk($sformatf("R5 clean after clear %0d", t), status_q, 32'h0);
    end

    // R6: words outside the covered set
    above_m = above_m ^ 32'hFFFF_FFFF;
    below_m = below_m ^ 32'h0000_FFFF;
    idle(3 * TOTAL);
    chk("R6 uncovered ignored", status_q, 32'h0);

    // R7: set and clear in the same cycle, set wins
    txn_done = 1; txn_write = 1; txn_addr = 16'h0200; txn_data = 32'h7;
    status_wr = 1; status_wbit = 1;
    @(negedge clk);
    txn_done = 0; txn_write = 0; status_wr = 0; status_wbit = 0;
    chk("R7 set beats clear", status_q, 32'h1 << B);

    // R8: clearing the mask raises irq_n at once
    mask_wr = 1; mask_wbit = 0; @(negedge clk); mask_wr = 0;
    chk("R8 mask cleared", mask_q, 32'h0);
    chk("R8 irq_n high on mask clear", 32'(irq_n), 32'h1);
    chk("R7 flag still set", status_q, 32'h1 << B);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule